// File: doc/BRIEF.md
# Phase Core for a Direct Digital Synthesizer

This block is the numerically controlled phase engine of a direct digital synthesizer. A 32-bit accumulator advances by the frequency tuning word on every clock. A free-running time counter counts clocks since the last start-of-run pulse. The output phase word is the accumulator plus a 16-bit phase offset, left-aligned onto the 32-bit phase. A 12-bit amplitude word goes out alongside it for a downstream phase-to-amplitude converter.

New tuning word, offset and amplitude values are presented together with an update strobe. They enter a short pipeline and take effect a fixed two clocks after the strobe edge. How the accumulator behaves at that moment depends on the phase mode. The mode normally comes from a static default input, and a per-update override can replace it for one update.

In continuous mode the accumulator keeps running. In absolute mode it restarts from zero, so the output phase at the change equals the offset. In tracking mode it is loaded with the product of the new tuning word and the time count, which is the value it would hold had the new frequency been running since the start of the run. A start-of-run pulse zeroes the accumulator and the time counter, and it discards any update still in flight.

Top module: `nco_phase_core`

## Requirements
- R1: After reset, phase_out and amp_out are zero. With the reset tuning word of zero, phase_out stays zero on later cycles.
- R2: On each clock edge without a commit or run start, the accumulator grows by the active tuning word modulo 2^32. phase_out equals the accumulator plus the active offset shifted left by 16, modulo 2^32.
- R3: An update is captured on a rising edge where upd_stb is high. Its values become visible after the second following edge, the commit edge. Until then the old tuning word, offset and amplitude remain in effect.
- R4: In continuous mode (code 0), the accumulator is not reloaded. At the commit edge it advances by the old tuning word, and by the new one after that.
- R5: In absolute mode (code 1), the accumulator is zero after the commit edge, so phase_out then equals the new offset shifted left by 16.
- R6: In tracking mode (code 2), the accumulator after the commit edge is the new tuning word times T, modulo 2^32. T is the number of edges since the edge that sampled run_start.
- R7: When upd_mode_ovr is high, that update uses upd_mode; otherwise it uses cfg_mode. The unused code 3 behaves as continuous.
- R8: An edge that samples run_start leaves the accumulator and time count at zero. It keeps the active tuning word, offset and amplitude. It drops any update in the pipeline and any strobe in the same cycle.
- R9: Strobes on consecutive cycles each commit, in order, on consecutive cycles.
- R10: The 12-bit amplitude, full scale 4095, is output unchanged from its commit edge until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_start | input | 1 | Start-of-run pulse: clears accumulator and time count |
| cfg_mode | input | 2 | Default phase mode: 0 continuous, 1 absolute, 2 tracking |
| upd_stb | input | 1 | Update strobe |
| upd_ftw | input | 32 | New frequency tuning word |
| upd_pow | input | 16 | New phase offset word |
| upd_amp | input | 12 | New amplitude word |
| upd_mode_ovr | input | 1 | Use upd_mode instead of cfg_mode for this update |
| upd_mode | input | 2 | Phase mode for this update when overridden |
| phase_out | output | 32 | Accumulator plus left-aligned offset |
| amp_out | output | 12 | Active amplitude word |

## Verification
The bench goes after the commit boundary by checking the cycle just before each commit as well as the cycle of the commit. A design with a different latency would show new values one cycle early or old ones one cycle late. Tracking updates use a tuning word near 2^32, so the product overflows. A design that computed the product from the wrong time count, or off by one edge, would then give a phase that is off by a multiple of the tuning word.

Back-to-back strobes, a strobe in the same cycle as run_start, and a strobe followed one cycle later by run_start are all driven. Those cases expose a pipeline that drops updates, reorders them, or lets a flushed update commit after the run restarts. Override-versus-default and the unused mode code are each checked on their own: a wrong mode shows up at once as a zeroed or reloaded accumulator where continuity was expected.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    PM_CONT  = 2'd0,
    PM_ABS   = 2'd1,
    PM_TRACK = 2'd2,
    PM_RSVD  = 2'd3
  } pmode_e;

  // Number of edges from the strobe edge to the commit edge.
  localparam int unsigned COMMIT_LAT = 2;

endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n_a) begin
        if (!rst_n_a) q <= 1'b0;
        else          q <= 1'b1;
      end
      assign rst_n_s = q;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n_a) begin
        if (!rst_n_a) sr <= '0;
        else          sr <= {sr[STAGES-2:0], 1'b1};
      end
      assign rst_n_s = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/nco_time_base.sv
module nco_time_base #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  output logic [TIME_W-1:0] tcnt
);

  logic [TIME_W-1:0] tcnt_q, tcnt_d;

  always_comb begin
    if (run_start) tcnt_d = '0;
    else           tcnt_d = tcnt_q + {{(TIME_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  assign tcnt = tcnt_q;

  // R8: run start zeroes the time count
  a_r8_time_zero: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (tcnt_q == '0));

  // R6: time count steps by one per edge otherwise
  a_r6_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    !run_start |=> (tcnt_q == $past(tcnt_q) + 1'b1));

endmodule

// File: rtl/nco_upd_pipe.sv
module nco_upd_pipe
  import nco_pkg::*;
#(
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned POW_W  = 16,
  parameter int unsigned AMP_W  = 12,
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic [1:0]        cfg_mode,
  input  logic              stb,
  input  logic [FTW_W-1:0]  ftw,
  input  logic [POW_W-1:0]  pow,
  input  logic [AMP_W-1:0]  amp,
  input  logic              mode_ovr,
  input  logic [1:0]        mode,
  input  logic [TIME_W-1:0] tcnt,
  output logic              commit,
  output logic [FTW_W-1:0]  c_ftw,
  output logic [POW_W-1:0]  c_pow,
  output logic [AMP_W-1:0]  c_amp,
  output pmode_e            c_mode,
  output logic [FTW_W-1:0]  c_track
);

  // Time count value that will be current right after the commit edge.
  localparam logic [TIME_W-1:0] LEAD = TIME_W'(COMMIT_LAT + 1);

  // stage 1: capture
  logic              s1_valid_q, s1_valid_d, s1_en;
  logic [FTW_W-1:0]  s1_ftw_q;
  logic [POW_W-1:0]  s1_pow_q;
  logic [AMP_W-1:0]  s1_amp_q;
  pmode_e            s1_mode_q, mode_sel;
  logic [TIME_W-1:0] s1_time_q, s1_time_d;

  // stage 2: tracking product
  logic              s2_valid_q, s2_valid_d, s2_en;
  logic [FTW_W-1:0]  s2_ftw_q;
  logic [POW_W-1:0]  s2_pow_q;
  logic [AMP_W-1:0]  s2_amp_q;
  pmode_e            s2_mode_q;
  logic [FTW_W-1:0]  s2_prod_q, prod_d;
  logic [FTW_W-1:0]  t_ext;

  always_comb begin
    mode_sel   = pmode_e'(mode_ovr ? mode : cfg_mode);
    s1_en      = stb & ~run_start;
    s1_valid_d = s1_en;
    s1_time_d  = tcnt + LEAD;
    s2_en      = s1_valid_q & ~run_start;
    s2_valid_d = s2_en;
  end

  generate
    if (TIME_W >= FTW_W) begin : g_time_cut
      assign t_ext = s1_time_q[FTW_W-1:0];
    end else begin : g_time_pad
      assign t_ext = {{(FTW_W-TIME_W){1'b0}}, s1_time_q};
    end
  endgenerate

  assign prod_d = s1_ftw_q * t_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_ftw_q   <= '0;
      s1_pow_q   <= '0;
      s1_amp_q   <= '0;
      s1_mode_q  <= PM_CONT;
      s1_time_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (s1_en) begin
        s1_ftw_q  <= ftw;
        s1_pow_q  <= pow;
        s1_amp_q  <= amp;
        s1_mode_q <= mode_sel;
        s1_time_q <= s1_time_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_ftw_q   <= '0;
      s2_pow_q   <= '0;
      s2_amp_q   <= '0;
      s2_mode_q  <= PM_CONT;
      s2_prod_q  <= '0;
    end else begin
      s2_valid_q <= s2_valid_d;
      if (s2_en) begin
        s2_ftw_q  <= s1_ftw_q;
        s2_pow_q  <= s1_pow_q;
        s2_amp_q  <= s1_amp_q;
        s2_mode_q <= s1_mode_q;
        s2_prod_q <= prod_d;
      end
    end
  end

  assign commit  = s2_valid_q & ~run_start;
  assign c_ftw   = s2_ftw_q;
  assign c_pow   = s2_pow_q;
  assign c_amp   = s2_amp_q;
  assign c_mode  = s2_mode_q;
  assign c_track = s2_prod_q;

  // R8: run start empties the pipeline
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (!s1_valid_q && !s2_valid_q));

  // R9: a captured update always reaches the commit stage
  a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid_q && !run_start) |=> s2_valid_q);

  // R3: a strobe is captured on the next stage
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !run_start) |=> (s1_valid_q && s1_ftw_q == $past(ftw)));

  // R7: the override picks the per-update mode
  a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !run_start && mode_ovr) |=> (s1_mode_q == pmode_e'($past(mode))));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int unsigned FTW_W = 32,
  parameter int unsigned POW_W = 16,
  parameter int unsigned AMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             commit,
  input  logic [FTW_W-1:0] c_ftw,
  input  logic [POW_W-1:0] c_pow,
  input  logic [AMP_W-1:0] c_amp,
  input  pmode_e           c_mode,
  input  logic [FTW_W-1:0] c_track,
  output logic [FTW_W-1:0] phase_out,
  output logic [AMP_W-1:0] amp_out
);

  localparam int unsigned PAD_W = FTW_W - POW_W;

  logic [FTW_W-1:0] acc_q, acc_d, step;
  logic [FTW_W-1:0] ftw_q;
  logic [POW_W-1:0] pow_q;
  logic [AMP_W-1:0] amp_q;

  always_comb begin
    step = acc_q + ftw_q;
    if (run_start) begin
      acc_d = '0;
    end else if (commit) begin
      case (c_mode)
        PM_ABS:   acc_d = '0;
        PM_TRACK: acc_d = c_track;
        default:  acc_d = step;
      endcase
    end else begin
      acc_d = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q <= '0;
      pow_q <= '0;
      amp_q <= '0;
    end else if (commit) begin
      ftw_q <= c_ftw;
      pow_q <= c_pow;
      amp_q <= c_amp;
    end
  end

  assign phase_out = acc_q + {pow_q, {PAD_W{1'b0}}};
  assign amp_out   = amp_q;

  // R2: free accumulation between commits
  a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !run_start) |=> (acc_q == $past(acc_q) + $past(ftw_q)));

  // R4: continuous commits keep the running phase
  a_r4_cont_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (c_mode == PM_CONT || c_mode == PM_RSVD))
      |=> (acc_q == $past(acc_q) + $past(ftw_q)));

  // R5: absolute commits restart from zero
  a_r5_abs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && c_mode == PM_ABS) |=> (acc_q == '0));

  // R6: tracking commits load the precomputed product
  a_r6_track_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && c_mode == PM_TRACK) |=> (acc_q == $past(c_track)));

  // R8: run start clears the accumulator
  a_r8_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (acc_q == '0));

  // R10: amplitude holds between commits
  a_r10_amp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(amp_q));

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int unsigned FTW_W       = 32,
  parameter int unsigned POW_W       = 16,
  parameter int unsigned AMP_W       = 12,
  parameter int unsigned TIME_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [1:0]       cfg_mode,
  input  logic             upd_stb,
  input  logic [FTW_W-1:0] upd_ftw,
  input  logic [POW_W-1:0] upd_pow,
  input  logic [AMP_W-1:0] upd_amp,
  input  logic             upd_mode_ovr,
  input  logic [1:0]       upd_mode,
  output logic [FTW_W-1:0] phase_out,
  output logic [AMP_W-1:0] amp_out
);

  logic              rst_n_s;
  logic [TIME_W-1:0] tcnt;
  logic              commit;
  logic [FTW_W-1:0]  c_ftw, c_track;
  logic [POW_W-1:0]  c_pow;
  logic [AMP_W-1:0]  c_amp;
  pmode_e            c_mode;

  nco_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  nco_time_base #(.TIME_W(TIME_W)) u_time (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_start (run_start),
    .tcnt      (tcnt)
  );

  nco_upd_pipe #(
    .FTW_W (FTW_W), .POW_W (POW_W), .AMP_W (AMP_W), .TIME_W (TIME_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_start (run_start),
    .cfg_mode  (cfg_mode),
    .stb       (upd_stb),
    .ftw       (upd_ftw),
    .pow       (upd_pow),
    .amp       (upd_amp),
    .mode_ovr  (upd_mode_ovr),
    .mode      (upd_mode),
    .tcnt      (tcnt),
    .commit    (commit),
    .c_ftw     (c_ftw),
    .c_pow     (c_pow),
    .c_amp     (c_amp),
    .c_mode    (c_mode),
    .c_track   (c_track)
  );

  nco_phase_acc #(
    .FTW_W (FTW_W), .POW_W (POW_W), .AMP_W (AMP_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_start (run_start),
    .commit    (commit),
    .c_ftw     (c_ftw),
    .c_pow     (c_pow),
    .c_amp     (c_amp),
    .c_mode    (c_mode),
    .c_track   (c_track),
    .phase_out (phase_out),
    .amp_out   (amp_out)
  );

endmodule

// File: tb/sim_nco_phase_core.sv
`timescale 1ns/1ps
module sim_nco_phase_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_start;
  logic [1:0]  cfg_mode;
  logic        upd_stb;
  logic [31:0] upd_ftw;
  logic [15:0] upd_pow;
  logic [11:0] upd_amp;
  logic        upd_mode_ovr;
  logic [1:0]  upd_mode;
  logic [31:0] phase_out;
  logic [11:0] amp_out;

  always #10 clk = ~clk;

  nco_phase_core u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .cfg_mode(cfg_mode),
    .upd_stb(upd_stb), .upd_ftw(upd_ftw), .upd_pow(upd_pow), .upd_amp(upd_amp),
    .upd_mode_ovr(upd_mode_ovr), .upd_mode(upd_mode),
    .phase_out(phase_out), .amp_out(amp_out)
  );

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit done   = 0;

  always @(posedge clk) edge_n <= edge_n + 1;

  typedef struct {
    int          edge_i;
    logic [31:0] ph;
    logic [11:0] amp;
    int          req;
  } exp_t;
  exp_t q[$];

  // independent model of the requirements
  logic [31:0] m_base_acc = '0;
  int          m_base_edge = 0;
  logic [31:0] m_ftw = '0;
  logic [15:0] m_pow = '0;
  logic [11:0] m_amp = '0;
  int          m_run = 0;

  function automatic logic [31:0] acc_at(int e);
    logic [31:0] d;
    d = 32'(e - m_base_edge);
    return m_base_acc + m_ftw * d;
  endfunction

  task automatic push_exp(int e, int req);
    exp_t it;
    it.edge_i = e;
    it.ph     = acc_at(e) + {m_pow, 16'h0000};
    it.amp    = m_amp;
    it.req    = req;
    q.push_back(it);
  endtask

  task automatic model_commit(int c, logic [31:0] f, logic [15:0] p,
                              logic [11:0] a, int md);
    logic [31:0] nacc;
    if (md == 1)      nacc = '0;                   // R5
    else if (md == 2) nacc = f * 32'(c - m_run);    // R6
    else              nacc = acc_at(c - 1) + m_ftw; // R4, code 3 per R7
    m_base_acc  = nacc;
    m_base_edge = c;
    m_ftw = f; m_pow = p; m_amp = a;
  endtask

  task automatic model_run(int r);
    m_base_acc  = acc_at(r) & 32'h0;
    m_base_edge = r;
    m_run       = r;
  endtask

  // monitor: compares scoreboard items on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].edge_i <= edge_n) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.edge_i != edge_n) begin
        errors++;
        $display("FAIL R%0d: item for edge %0d missed (now %0d)", it.req, it.edge_i, edge_n);
      end else if (phase_out !== it.ph || amp_out !== it.amp) begin
        errors++;
        $display("FAIL R%0d: edge %0d phase %h amp %h, expected phase %h amp %h",
                 it.req, edge_n, phase_out, amp_out, it.ph, it.amp);
      end
    end
  end

  task automatic chk(int req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int eff_mode(logic ovr, logic [1:0] md);
    return ovr ? int'(md) : int'(cfg_mode);
  endfunction

  // one update; checks the cycle before commit (R3) and after it
  task automatic upd(logic [31:0] f, logic [15:0] p, logic [11:0] a,
                     logic ovr, logic [1:0] md, int req);
    int s, c;
    @(negedge clk);
    upd_stb = 1'b1; upd_ftw = f; upd_pow = p; upd_amp = a;
    upd_mode_ovr = ovr; upd_mode = md;
    s = edge_n + 1;
    c = s + 2;
    push_exp(c - 1, 3); // R3: old values before the commit edge
    model_commit(c, f, p, a, eff_mode(ovr, md));
    push_exp(c, req);
    push_exp(c + 1, 2); // R2
    push_exp(c + 3, req);
    @(negedge clk);
    upd_stb = 1'b0; upd_mode_ovr = 1'b0;
    idle(5);
  endtask

  task automatic pulse_run(logic with_stb);
    int r;
    @(negedge clk);
    run_start = 1'b1;
    if (with_stb) begin
      upd_stb = 1'b1; upd_ftw = 32'h7777_0000; upd_pow = 16'h9999; upd_amp = 12'hEEE;
    end
    r = edge_n + 1;
    model_run(r);         // R8: strobe in the same cycle is dropped
    push_exp(r, 8);
    push_exp(r + 1, 8);
    push_exp(r + 3, 8);
    @(negedge clk);
    run_start = 1'b0; upd_stb = 1'b0;
    idle(5);
  endtask

  initial begin
    rst_n = 1'b0; run_start = 1'b0; cfg_mode = 2'd0; upd_stb = 1'b0;
    upd_ftw = '0; upd_pow = '0; upd_amp = '0; upd_mode_ovr = 1'b0; upd_mode = 2'd0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk(1, phase_out, 32'h0);
    chk(1, 32'(amp_out), 32'h0);
    idle(3);
    chk(1, phase_out, 32'h0);

    pulse_run(1'b0);

    // R5, R10: absolute by default, full-scale amplitude
    cfg_mode = 2'd1;
    upd(32'h0100_0000, 16'h4000, 12'd4095, 1'b0, 2'd0, 5);
    // R4: continuous by default
    cfg_mode = 2'd0;
    upd(32'h0030_0001, 16'h1234, 12'h0AB, 1'b0, 2'd0, 4);
    // R6, R7: tracking via override
    upd(32'h0012_3457, 16'h0000, 12'h7FF, 1'b1, 2'd2, 6);
    // R7: absolute override while default is tracking
    cfg_mode = 2'd2;
    upd(32'h0000_8000, 16'h8000, 12'h001, 1'b1, 2'd1, 7);
    // R6: tracking by default, product wraps past 2^32
    upd(32'hFFFF_FFF3, 16'h00FF, 12'h100, 1'b0, 2'd0, 6);
    // R7: code 3 acts as continuous
    upd(32'h0200_0000, 16'h1111, 12'h222, 1'b1, 2'd3, 7);

    // R9: back-to-back strobes
    cfg_mode = 2'd0;
    begin
      int s, c;
      @(negedge clk);
      upd_stb = 1'b1; upd_ftw = 32'h0001_0001; upd_pow = 16'h2222; upd_amp = 12'h333;
      upd_mode_ovr = 1'b1; upd_mode = 2'd2;
      s = edge_n + 1; c = s + 2;
      push_exp(c - 1, 3);
      model_commit(c, 32'h0001_0001, 16'h2222, 12'h333, 2);
      push_exp(c, 9);
      model_commit(c + 1, 32'h0040_0000, 16'h4444, 12'h555, 1);
      push_exp(c + 1, 9);
      push_exp(c + 2, 9);
      push_exp(c + 4, 9);
      @(negedge clk);
      upd_ftw = 32'h0040_0000; upd_pow = 16'h4444; upd_amp = 12'h555; upd_mode = 2'd1;
      @(negedge clk);
      upd_stb = 1'b0; upd_mode_ovr = 1'b0;
      idle(6);
    end

    // R8: strobe in the same cycle as run start is dropped
    pulse_run(1'b1);

    // R8: run start one cycle after a strobe flushes it
    begin
      int r;
      @(negedge clk);
      upd_stb = 1'b1; upd_ftw = 32'h5555_5555; upd_pow = 16'hAAAA; upd_amp = 12'hBBB;
      upd_mode_ovr = 1'b1; upd_mode = 2'd1;
      @(negedge clk);
      upd_stb = 1'b0; upd_mode_ovr = 1'b0; run_start = 1'b1;
      r = edge_n + 1;
      model_run(r);
      push_exp(r, 8);
      push_exp(r + 1, 8);
      push_exp(r + 2, 8);
      push_exp(r + 4, 8);
      @(negedge clk);
      run_start = 1'b0;
      idle(6);
    end

    // R6, R8: tracking measured from the new run start
    upd(32'h0ABC_DEF1, 16'h0F0F, 12'h444, 1'b1, 2'd2, 6);

    idle(4);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d scoreboard items never compared, expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule